// File: doc/BRIEF.md
# Memory Hot-Page Tracking Unit

This block sits next to a memory device controller and watches the request stream the controller services. Requests that were not served from a cache are counted per address unit. The unit size is a power of two chosen by software, and units map into a fixed table of counters. Counting runs in epochs, each a programmable number of cycles long. The first time in an epoch that a unit's count rises strictly above a programmable threshold, the unit's index is queued in a 16-entry circular hotlist.

Software drains the hotlist through a pop port. It can poll the pop port, or it can wait for a level interrupt that is raised while the hotlist holds at least a programmed number of entries. A hotlist overflow is remembered in a sticky flag.

Configuration uses a write-only register port. The register index is on `cfg_addr_i`:

| Index | Contents |
|-------|----------|
| 0 | bit0 counting enable, bit1 interrupt enable |
| 1 | unit shift, bits [5:0] |
| 2 | threshold, bits [15:0] |
| 3 | epoch length in cycles, bits [23:0] |
| 4 | interrupt watermark, bits [4:0] |
| 5 | any write clears the overflow flag |

Top module: `hot_page_tracker`

## Requirements
- R1: A request with `req_cache_hit_i`=1 leaves every counter unchanged.
- R2: The unit index of a request is (address >> shift) mod 64, where shift is the value in register 1.
- R3: A unit's index is pushed to the hotlist when an access makes its count strictly greater than the threshold in register 2. A unit is pushed at most once per epoch, and the entry can be popped from the cycle after that access.
- R4: The epoch timer counts enabled cycles. In the cycle that ends an epoch of the length in register 3, all counters and reported flags are cleared, and an access in that same cycle is counted as the first access of the new epoch.
- R5: The hotlist holds up to 16 entries and returns them in push order. `level_o` gives the number of entries held.
- R6: A push into a full hotlist is dropped and sets `overflow_o`. The flag stays set until register 5 is written.
- R7: `pop_valid_o` is 1 only when `pop_i` is 1 and the hotlist is not empty. In that case `pop_unit_o` carries the oldest entry in the same cycle. A pop on an empty hotlist has no effect.
- R8: A pop and a push in the same cycle both take effect, and `level_o` stays unchanged. This also holds when the hotlist is full.
- R9: `irq_o` is 1 exactly while the interrupt enable (register 0 bit1) is set and `level_o` is at or above the watermark in register 4.
- R10: While the counting enable (register 0 bit0) is 0, no access is counted, nothing is pushed, and the epoch timer is held at zero. The first epoch therefore starts at the enabling write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Observed request valid |
| req_addr_i | input | 40 | Observed request address |
| req_cache_hit_i | input | 1 | Request was served by a cache |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register index |
| cfg_wdata_i | input | 32 | Register write data |
| pop_i | input | 1 | Pop the oldest hotlist entry |
| pop_valid_o | output | 1 | Pop returned an entry |
| pop_unit_o | output | 6 | Popped unit index |
| level_o | output | 5 | Hotlist occupancy |
| overflow_o | output | 1 | Sticky hotlist overflow |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench targets several corner cases, each with the symptom a faulty design would show:
- Strict crossing. An off-by-one compare would publish a unit one access too early.
- Re-push suppression. If suppression fails, the same unit appears twice in one epoch.
- Epoch-boundary access. A design that clears after counting would lose that access, and one that never clears would publish the unit early.
- Full ring. The bench fills the ring past capacity, then checks that the extra unit is dropped, that entry order is kept, and that the overflow flag persists until it is cleared.
- Simultaneous pop and push. A design that lets one side win would change the occupancy.
- Disabled state. Accesses made while counting is disabled must leave no trace.
- Interrupt level. The bench follows the interrupt across the watermark in both directions.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_SHIFT  = 3'd1,
    REG_THRESH = 3'd2,
    REG_EPOCH  = 3'd3,
    REG_WMARK  = 3'd4,
    REG_OVFCLR = 3'd5
  } cfg_reg_e;

  typedef struct packed {
    logic irq_en;
    logic count_en;
  } ctrl_t;
endpackage

// File: rtl/hpt_epoch_timer.sv
module hpt_epoch_timer #(
  parameter int EPOCH_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [EPOCH_W-1:0] len_i,
  output logic               tick_o
);
  logic [EPOCH_W-1:0] cnt_q;

  // >= so that shortening the length mid-epoch still ends the epoch
  assign tick_o = en_i && (({1'b0, cnt_q} + 1'b1) >= {1'b0, len_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  a_r10_timer_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/hpt_counter_table.sv
module hpt_counter_table #(
  parameter int ADDR_W = 40,
  parameter int UNITS  = 64,
  parameter int CNT_W  = 16,
  localparam int IDX_W = $clog2(UNITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clear_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_hit_i,
  input  logic [5:0]        shift_i,
  input  logic [CNT_W-1:0]  thr_i,
  output logic              push_o,
  output logic [IDX_W-1:0]  push_idx_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  cnt_q [UNITS];
  logic [UNITS-1:0]  rep_q;
  logic [ADDR_W-1:0] shifted;
  logic [CNT_W-1:0]  cur, nxt;
  logic              cur_rep, take;

  assign take       = en_i && req_valid_i && !req_hit_i;
  assign shifted    = req_addr_i >> shift_i;
  assign push_idx_o = shifted[IDX_W-1:0];
  assign cur        = clear_i ? '0 : cnt_q[push_idx_o];
  assign cur_rep    = clear_i ? 1'b0 : rep_q[push_idx_o];
  assign nxt        = (cur == CNT_MAX) ? cur : cur + 1'b1;
  assign push_o     = take && (nxt > thr_i) && !cur_rep;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < UNITS; i++) cnt_q[i] <= '0;
      rep_q <= '0;
    end else begin
      if (clear_i) begin
        for (int i = 0; i < UNITS; i++) cnt_q[i] <= '0;
        rep_q <= '0;
      end
      if (take)   cnt_q[push_idx_o] <= nxt;
      if (push_o) rep_q[push_idx_o] <= 1'b1;
    end
  end

  a_r1_hit_no_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_hit_i) |-> !push_o);
  a_r10_no_push_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !push_o);
endmodule

// File: rtl/hpt_ring.sv
module hpt_ring #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 6,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic              pop_valid_o,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [PTR_W:0]    level_o,
  input  logic              ovf_clr_i,
  output logic              ovf_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q;
  logic              push_ok, full;

  assign full        = (level_o == DEPTH[PTR_W:0]);
  assign pop_valid_o = pop_i && (level_o != '0);
  assign pop_data_o  = mem_q[head_q];
  assign push_ok     = push_i && (!full || pop_valid_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      level_o <= '0;
      ovf_o   <= 1'b0;
    end else begin
      if (push_ok) begin
        mem_q[tail_q] <= data_i;
        tail_q        <= tail_q + 1'b1;
      end
      if (pop_valid_o) head_q <= head_q + 1'b1;
      level_o <= level_o + {{PTR_W{1'b0}}, push_ok} - {{PTR_W{1'b0}}, pop_valid_o};
      if (push_i && !push_ok) ovf_o <= 1'b1;
      else if (ovf_clr_i)     ovf_o <= 1'b0;
    end
  end

  a_r5_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= DEPTH[PTR_W:0]);
  a_r6_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
  a_r7_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && level_o == '0) |-> !pop_valid_o);
  a_r8_push_pop_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && level_o != '0) |=> $stable(level_o));
endmodule

// File: rtl/hot_page_tracker.sv
module hot_page_tracker
  import hpt_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int UNITS     = 64,
  parameter int CNT_W     = 16,
  parameter int DEPTH     = 16,
  parameter int EPOCH_W   = 24,
  parameter int EPOCH_RST = 1024,
  localparam int IDX_W    = $clog2(UNITS),
  localparam int LVL_W    = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_cache_hit_i,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              pop_i,
  output logic              pop_valid_o,
  output logic [IDX_W-1:0]  pop_unit_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              overflow_o,
  output logic              irq_o
);
  ctrl_t              ctrl_q;
  logic [5:0]         shift_q;
  logic [CNT_W-1:0]   thr_q;
  logic [EPOCH_W-1:0] epoch_q;
  logic [LVL_W-1:0]   wmark_q;
  logic               tick, push, ovf_clr;
  logic [IDX_W-1:0]   push_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      shift_q <= '0;
      thr_q   <= '0;
      epoch_q <= EPOCH_W'(EPOCH_RST);
      wmark_q <= LVL_W'(1);
    end else if (cfg_we_i) begin
      case (cfg_reg_e'(cfg_addr_i))
        REG_CTRL:   ctrl_q  <= ctrl_t'(cfg_wdata_i[1:0]);
        REG_SHIFT:  shift_q <= cfg_wdata_i[5:0];
        REG_THRESH: thr_q   <= cfg_wdata_i[CNT_W-1:0];
        REG_EPOCH:  epoch_q <= cfg_wdata_i[EPOCH_W-1:0];
        REG_WMARK:  wmark_q <= cfg_wdata_i[LVL_W-1:0];
        default: ;
      endcase
    end
  end

  assign ovf_clr = cfg_we_i && (cfg_reg_e'(cfg_addr_i) == REG_OVFCLR);
  assign irq_o   = ctrl_q.irq_en && (level_o >= wmark_q);

  hpt_epoch_timer #(.EPOCH_W(EPOCH_W)) u_timer (
    .clk_i, .rst_ni, .en_i(ctrl_q.count_en), .len_i(epoch_q), .tick_o(tick)
  );

  hpt_counter_table #(.ADDR_W(ADDR_W), .UNITS(UNITS), .CNT_W(CNT_W)) u_table (
    .clk_i, .rst_ni, .en_i(ctrl_q.count_en), .clear_i(tick),
    .req_valid_i, .req_addr_i, .req_hit_i(req_cache_hit_i),
    .shift_i(shift_q), .thr_i(thr_q), .push_o(push), .push_idx_o(push_idx)
  );

  hpt_ring #(.DEPTH(DEPTH), .DATA_W(IDX_W)) u_ring (
    .clk_i, .rst_ni, .push_i(push), .data_i(push_idx), .pop_i,
    .pop_valid_o, .pop_data_o(pop_unit_o), .level_o,
    .ovf_clr_i(ovf_clr), .ovf_o(overflow_o)
  );

  a_r9_irq_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.irq_en) |-> !irq_o);
endmodule

// File: tb/tb_hot_page_tracker.sv
module tb_hot_page_tracker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_ni = 0;
  logic        req_valid = 0, req_hit = 0, cfg_we = 0, pop = 0;
  logic [39:0] req_addr = '0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        pop_valid, overflow, irq;
  logic [5:0]  pop_unit;
  logic [4:0]  level;

  int checks = 0, errors = 0;
  int m_cnt [64];
  bit m_rep [64];
  int exp_q [$];
  bit m_en = 0, m_irqen = 0, m_ovf = 0;
  int m_shift = 0, m_thr = 0, m_wm = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  hot_page_tracker dut (
    .clk_i(clk), .rst_ni, .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_cache_hit_i(req_hit), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .pop_i(pop), .pop_valid_o(pop_valid),
    .pop_unit_o(pop_unit), .level_o(level), .overflow_o(overflow), .irq_o(irq)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    check({req, " level"}, level, exp_q.size());
    check({req, " overflow"}, overflow, m_ovf);
    check({req, " irq"}, irq, m_irqen && (exp_q.size() >= m_wm));
  endtask

  task automatic cfg_write(int a, int d);
    cfg_we = 1; cfg_addr = a[2:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    case (a)
      0: begin m_en = d[0]; m_irqen = d[1]; end
      1: m_shift = d;
      2: m_thr = d;
      4: m_wm = d;
      5: m_ofv_clear();
      default: ;
    endcase
  endtask

  function automatic void m_ofv_clear();
    m_ovf = 0;
  endfunction

  function automatic void model_clear();
    for (int i = 0; i < 64; i++) begin m_cnt[i] = 0; m_rep[i] = 0; end
  endfunction

  // driver side: model the access, queue the expected hotlist entry
  function automatic void model_access(logic [39:0] a, bit hit, bit popping);
    int idx;
    idx = int'((a >> m_shift) % 64);
    if (!m_en || hit) return;
    if (m_cnt[idx] < 65535) m_cnt[idx]++;
    if (m_cnt[idx] > m_thr && !m_rep[idx]) begin
      m_rep[idx] = 1;
      if (exp_q.size() < 16 || popping) exp_q.push_back(idx);
      else m_ovf = 1;
    end
  endfunction

  function automatic logic [39:0] addr_of(int u);
    return (40'(u) << m_shift) | 40'(m_shift > 0 ? 1 : 0);
  endfunction

  task automatic access(logic [39:0] a, bit hit);
    req_valid = 1; req_addr = a; req_hit = hit;
    @(negedge clk);
    req_valid = 0; req_hit = 0;
    model_access(a, hit, 0);
  endtask

  // monitor side: pop and compare against the expected queue
  task automatic pop_check(string req);
    int e;
    pop = 1;
    #1;
    if (exp_q.size() == 0) check({req, " empty pop valid"}, pop_valid, 0);
    else begin
      e = exp_q.pop_front();
      check({req, " pop valid"}, pop_valid, 1);
      check({req, " pop unit"}, pop_unit, e);
    end
    @(negedge clk);
    pop = 0;
  endtask

  task automatic access_pop(logic [39:0] a, string req);
    int e;
    req_valid = 1; req_addr = a; req_hit = 0; pop = 1;
    #1;
    e = exp_q.pop_front();
    check({req, " pop valid"}, pop_valid, 1);
    check({req, " pop unit"}, pop_unit, e);
    @(negedge clk);
    req_valid = 0; pop = 0;
    model_access(a, 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check_state("reset");
    pop_check("R7 reset");

    cfg_write(1, 6); cfg_write(2, 2); cfg_write(3, 150000); cfg_write(4, 4);
    // R10: disabled, nothing counted
    for (int i = 0; i < 5; i++) access(addr_of(1), 0);
    check_state("R10 disabled");
    cfg_write(0, 1);
    access(addr_of(1), 0); access(addr_of(1), 0);
    check_state("R10 no stale counts");
    // R1: hits ignored
    for (int i = 0; i < 5; i++) access(addr_of(3), 1);
    access(addr_of(3), 0); access(addr_of(3), 0);
    check_state("R1 hits ignored");
    access(addr_of(3), 0);
    check_state("R3 strict crossing");
    access(addr_of(3), 0);
    check_state("R3 once per epoch");
    pop_check("R3");
    // R2: index from shift
    access(40'd64*70 + 5, 0); access(40'd64*70 + 9, 0); access(40'd64*70 + 63, 0);
    cfg_write(1, 10);
    for (int i = 0; i < 3; i++) access(40'h2C00 + 40'(i * 100), 0);
    check_state("R2 pushes");
    pop_check("R2 R5 order");
    pop_check("R2 R5 order");
    pop_check("R7 empty");
    cfg_write(1, 6);
    // R9: interrupt around watermark
    cfg_write(0, 3);
    for (int u = 20; u < 24; u++) begin
      for (int k = 0; k < 3; k++) access(addr_of(u), 0);
      check_state("R9 rising");
    end
    // R8: pop and push together
    access(addr_of(24), 0); access(addr_of(24), 0);
    access_pop(addr_of(24), "R8");
    check_state("R8 level kept");
    for (int i = 0; i < 4; i++) begin pop_check("R9 drain"); check_state("R9 falling"); end
    // R6: overflow
    cfg_write(2, 0);
    for (int u = 30; u < 47; u++) access(addr_of(u), 0);
    check_state("R6 full");
    access_pop(addr_of(47), "R8 full");
    check_state("R8 full level");
    for (int i = 0; i < 16; i++) pop_check("R5 R6 drain");
    check_state("R6 sticky");
    cfg_write(5, 0);
    check_state("R6 cleared");
    // R4: epoch boundary
    cfg_write(0, 0); cfg_write(3, 10); cfg_write(2, 1);
    cfg_write(0, 1);                       // c1 begins
    access(addr_of(50), 0); access(addr_of(50), 0);  // c1, c2
    pop_check("R4 first epoch");           // c3
    repeat (5) @(negedge clk);             // c4..c8
    access(addr_of(51), 0);                // c9
    model_clear();
    access(addr_of(51), 0);                // c10: boundary
    check_state("R4 boundary access");
    access(addr_of(51), 0);                // c11
    access(addr_of(50), 0); access(addr_of(50), 0);  // c12, c13
    check_state("R4 new epoch");
    pop_check("R4 order"); pop_check("R4 order");
    check_state("R4 drained");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule